// File: doc/BRIEF.md
# DDR Write Strobe Scheduler

This block sits on the controller side of a DDR4-style memory interface. For each WRITE command it marks, cycle by cycle, when the data strobe must be driven, which cycles form the strobe preamble, which cycles carry data, and the closing postamble. The write latency comes from a lookup on a speed-bin code, the preamble length (one or two clocks) and a primary/alternate latency select. The block also flags illegal settings and WRITE commands issued closer together than the minimum spacing allows.

Each command runs down a shift register. The strobe and data windows are decoded from the command's position relative to the latched latency. Configuration is latched only while no write is in flight, so a burst always finishes with the settings it started with. When bursts are issued back to back four clocks apart, the strobe runs without interruption: there is no second preamble and no intermediate postamble.

Top module: `ddr_wr_strobe_sched`

## Requirements
- R1: With the one-clock preamble, write latency `cwl` for `bin_code` 0,1,2,3,4,5,6 is 9,10,11,12,14,16,16 with `alt_sel`=0 and 11,12,14,16,18,20,20 with `alt_sel`=1. Code 7 behaves as code 6.
- R2: With the two-clock preamble accepted (`pre2_active`=1), the primary latency is the one-clock value plus 2 (14,16,18,18 for codes 3,4,5,6). The alternate latency is unchanged.
- R3: Requesting the two-clock preamble with `bin_code` 0, 1 or 2 sets `cfg_illegal`, keeps `pre2_active` at 0 and uses the one-clock latency. Code 7 also sets `cfg_illegal`.
- R4: For a write sampled at clock edge T, `dqs_pre` is high for the P cycles just before data: cycles T+cwl-P to T+cwl-1, where P is 1 or 2 per `pre2_active`. `dqs_hi` is 0 during the preamble. `dqs_pre` is never high in a data cycle.
- R5: `dq_valid` and `dqs_hi` are high for the four cycles T+cwl to T+cwl+3, which carry eight data beats.
- R6: In the cycle after the last data cycle, if no preamble is due, `dqs_post` and `dqs_oe` are high and `dqs_hi` is low. `dqs_oe` then drops. `dqs_oe` is high exactly in preamble, data and postamble cycles.
- R7: Writes four cycles apart give one continuous run of `dq_valid`, with no `dqs_pre` or `dqs_post` between the bursts.
- R8: A write issued d cycles after the previous one raises `spacing_err` in cycle T (one cycle after sampling) when d < 6 with `same_bg`=1, or d < 4 with `same_bg`=0.
- R9: `twr_eff` = TWR_NOM + `pre2_active` and `twtr_eff` = TWTR_NOM + `pre2_active` (defaults 16 and 4).
- R10: `bin_code`, `pre2_req` and `alt_sel` are latched only while no write is in flight. A change during a burst has no effect on that burst or on `cwl` until the pipeline drains.
- R11: After reset, `dqs_oe`, `dqs_pre`, `dq_valid`, `dqs_post`, `dqs_hi`, `spacing_err`, `cfg_illegal` and `pre2_active` are 0 and `cwl` is 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | WRITE command pulse |
| same_bg | input | 1 | This write targets the same bank group as the previous one |
| bin_code | input | 3 | Speed-bin code, 0 = slowest |
| pre2_req | input | 1 | Request two-clock preamble |
| alt_sel | input | 1 | Select alternate latency set |
| cwl | output | 5 | Latched write latency in clocks |
| pre2_active | output | 1 | Two-clock preamble in use |
| cfg_illegal | output | 1 | Latched configuration is illegal |
| twr_eff | output | 6 | Exported write-recovery count |
| twtr_eff | output | 6 | Exported write-to-read count |
| dqs_oe | output | 1 | Strobe output enable |
| dqs_pre | output | 1 | Preamble cycle |
| dqs_hi | output | 1 | Strobe toggles this cycle (high then low) |
| dq_valid | output | 1 | Data cycle (two beats) |
| dqs_post | output | 1 | Postamble cycle, strobe held low |
| spacing_err | output | 1 | Minimum write spacing violated |

## Verification
Single bursts are run at a short and a long latency, in both preamble modes. These runs separate an off-by-one in the latency index from an error in the preamble width.

Pairs of writes are also run at spacings of 4, 5 and 7 cycles. The 4-cycle pair checks the seamless merge. The 5-cycle pair checks a preamble that abuts the previous data. The 7-cycle pair checks a full postamble followed by a fresh preamble.

A spacing of 5 is run once with the same bank group and once with a different one. This shows that the spacing limit follows `same_bg`. A configuration change in mid-burst shows that the latch waits for the pipeline to drain.

// File: rtl/ddr_wr_strobe_sched.sv
module ddr_wr_strobe_sched #(
  parameter int TWR_NOM  = 16,
  parameter int TWTR_NOM = 4,
  parameter int TCCD_S   = 4,
  parameter int TCCD_L   = 6,
  parameter int DEPTH    = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic       same_bg,
  input  logic [2:0] bin_code,
  input  logic       pre2_req,
  input  logic       alt_sel,
  output logic [4:0] cwl,
  output logic       pre2_active,
  output logic       cfg_illegal,
  output logic [5:0] twr_eff,
  output logic [5:0] twtr_eff,
  output logic       dqs_oe,
  output logic       dqs_pre,
  output logic       dqs_hi,
  output logic       dq_valid,
  output logic       dqs_post,
  output logic       spacing_err
);
  localparam logic [3:0] LIM_S = 4'(TCCD_S);
  localparam logic [3:0] LIM_L = 4'(TCCD_L);

  logic [DEPTH-1:0] sr;
  logic [3:0]       gap;
  logic             vld_q;
  logic [4:0]       p1_wl, alt_wl, n_wl;
  logic             n_p2, n_ill, low_bin;
  logic [DEPTH-1:0] vmask, pmask;

  always_comb begin
    case (bin_code)
      3'd0:    begin p1_wl = 5'd9;  alt_wl = 5'd11; end
      3'd1:    begin p1_wl = 5'd10; alt_wl = 5'd12; end
      3'd2:    begin p1_wl = 5'd11; alt_wl = 5'd14; end
      3'd3:    begin p1_wl = 5'd12; alt_wl = 5'd16; end
      3'd4:    begin p1_wl = 5'd14; alt_wl = 5'd18; end
      default: begin p1_wl = 5'd16; alt_wl = 5'd20; end
    endcase
  end

  assign low_bin = (bin_code < 3'd3);
  assign n_p2    = pre2_req & ~low_bin;
  assign n_ill   = (pre2_req & low_bin) | (bin_code == 3'd7);
  assign n_wl    = alt_sel ? alt_wl : (p1_wl + (n_p2 ? 5'd2 : 5'd0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwl         <= 5'd9;
      pre2_active <= 1'b0;
      cfg_illegal <= 1'b0;
      sr          <= '0;
      gap         <= '0;
      vld_q       <= 1'b0;
      spacing_err <= 1'b0;
    end else begin
      if (sr == '0) begin
        cwl         <= n_wl;
        pre2_active <= n_p2;
        cfg_illegal <= n_ill;
      end
      sr          <= {sr[DEPTH-2:0], wr_cmd};
      vld_q       <= dq_valid;
      spacing_err <= wr_cmd && (gap != 4'd0) && (gap < (same_bg ? LIM_L : LIM_S));
      if (wr_cmd)            gap <= 4'd1;
      else if (gap != 4'd0 && gap != 4'd15) gap <= gap + 4'd1;
    end
  end

  assign vmask    = DEPTH'(4'hF) << cwl;
  assign pmask    = pre2_active ? (DEPTH'(2'b11) << (cwl - 5'd2)) : (DEPTH'(1'b1) << (cwl - 5'd1));
  assign dq_valid = |(sr & vmask);
  assign dqs_hi   = dq_valid;
  assign dqs_pre  = (|(sr & pmask)) & ~dq_valid;
  assign dqs_post = vld_q & ~dq_valid & ~dqs_pre;
  assign dqs_oe   = dq_valid | dqs_pre | dqs_post;
  assign twr_eff  = 6'(TWR_NOM) + {5'b0, pre2_active};
  assign twtr_eff = 6'(TWTR_NOM) + {5'b0, pre2_active};

  assert_pre_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dqs_pre && dq_valid));
  assert_post_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_post |-> $past(dq_valid));
  assert_release_after_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_oe) |-> $past(dqs_post));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|sr) |=> $stable(cwl) && $stable(pre2_active));
  assert_pre2_bin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre2_active |-> (cwl >= 5'd14));
endmodule

// File: tb/sim_ddr_wr_strobe_sched.sv
`timescale 1ns/1ps
module sim_ddr_wr_strobe_sched;
  logic clk = 1'b0, rst_n = 1'b0, wr_cmd = 1'b0, same_bg = 1'b0;
  logic [2:0] bin_code = 3'd0;
  logic pre2_req = 1'b0, alt_sel = 1'b0;
  logic [4:0] cwl;
  logic pre2_active, cfg_illegal, dqs_oe, dqs_pre, dqs_hi, dq_valid, dqs_post, spacing_err;
  logic [5:0] twr_eff, twtr_eff;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ddr_wr_strobe_sched u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lut(input int b, input bit p2, input bit alt);
    int p1[8] = '{9, 10, 11, 12, 14, 16, 16, 16};
    int a[8]  = '{11, 12, 14, 16, 18, 20, 20, 20};
    if (alt) return a[b];
    return p1[b] + ((p2 && b >= 3) ? 2 : 0);
  endfunction

  task automatic setcfg(input int b, input bit p2, input bit alt);
    @(negedge clk);
    bin_code = 3'(b); pre2_req = p2; alt_sel = alt;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_cfg(input int b, input bit p2, input bit alt);
    bit ill, act2;
    setcfg(b, p2, alt);
    ill  = (p2 && b < 3) || b == 7;
    act2 = p2 && b >= 3;
    chk(cwl == 5'(lut(b, p2, alt)), p2 ? "R2 cwl" : "R1 cwl", cwl, lut(b, p2, alt));
    chk(cfg_illegal == ill && pre2_active == act2, "R3 flag/fallback",
        {cfg_illegal, pre2_active}, {ill, act2});
    chk(twr_eff == 6'(16 + act2) && twtr_eff == 6'(4 + act2), "R9 recovery counts",
        {twr_eff, twtr_eff}, {6'(16 + act2), 6'(4 + act2)});
  endtask

  task automatic run(input logic [39:0] mask, input int wl, input int p, input bit sbg,
                     input int chg, input string nm);
    bit pv = 0;
    int last = -1;
    for (int c = 0; c < 40; c++) begin
      bit ev = 0, ep = 0, epo, eerr;
      logic [5:0] got, exp;
      wr_cmd = mask[c]; same_bg = sbg;
      if (c == chg) begin bin_code = 3'd6; alt_sel = 1'b1; end
      @(posedge clk); @(negedge clk);
      for (int w = 0; w <= c; w++)
        if (mask[w]) begin
          if (c - w >= wl && c - w <= wl + 3) ev = 1;
          if (c - w >= wl - p && c - w <= wl - 1) ep = 1;
        end
      ep   = ep && !ev;
      epo  = pv && !ev && !ep;
      eerr = mask[c] && last >= 0 && (c - last) < (sbg ? 6 : 4);
      if (mask[c]) last = c;
      pv   = ev;
      got  = {dqs_oe, dqs_pre, dq_valid, dqs_post, dqs_hi, spacing_err};
      exp  = {ev | ep | epo, ep, ev, epo, ev, eerr};
      chk(got == exp, {"R4 R5 R6 R7 R8 ", nm}, got, exp);
      if (chg >= 0 && c == chg + 1) chk(cwl == 5'(wl), "R10 cwl held", cwl, wl);
    end
    wr_cmd = 1'b0;
  endtask

  task automatic t_reset;
    chk({dqs_oe, dqs_pre, dq_valid, dqs_post, dqs_hi, spacing_err, cfg_illegal, pre2_active} == 8'h0
        && cwl == 5'd9, "R11 reset", {dqs_oe, dq_valid, cwl}, 9);
  endtask

  task automatic t_change_mid;
    setcfg(3, 0, 0);
    run(40'h1, 12, 1, 0, 1, "R10 burst");
    repeat (2) @(negedge clk);
    chk(cwl == 5'd20, "R10 applied after idle", cwl, 20);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int b = 0; b < 8; b++) begin
      t_cfg(b, 0, 0); t_cfg(b, 0, 1); t_cfg(b, 1, 0); t_cfg(b, 1, 1);
    end
    setcfg(3, 0, 0); run(40'h1, 12, 1, 0, -1, "single 1tCK");
    setcfg(6, 1, 0); run(40'h1, 18, 2, 0, -1, "single 2tCK");
    setcfg(0, 0, 0); run(40'h1, 9, 1, 0, -1, "single short");
    setcfg(4, 1, 0); run(40'h11, 16, 2, 0, -1, "R7 seamless 2tCK");
    setcfg(3, 0, 0); run(40'h11, 12, 1, 0, -1, "R7 seamless 1tCK");
    setcfg(5, 1, 1); run(40'h21, 20, 2, 0, -1, "gap5 2tCK");
    setcfg(3, 0, 0); run(40'h81, 12, 1, 0, -1, "gap7 post then pre");
    setcfg(3, 0, 0); run(40'h21, 12, 1, 1, -1, "R8 same bg gap5");
    setcfg(3, 0, 0); run(40'h9, 12, 1, 0, -1, "R8 diff bg gap3");
    t_change_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule